// File: doc/BRIEF.md
# Banked Monitor Register Front End

This block sits behind an already-decoded byte register interface of a hardware-monitor device. Each cycle it may take one register write, one register read, or both. Every access carries an 8-bit register address. A page register at the top of the address space chooses which of several 256-byte storage pages the other addresses reach. Three identification bytes and the page register itself answer at the same addresses whatever page is active.

Page 0 also holds a run of ten latched alarm status bytes. Each bit is set by a one-cycle event input and stays set until a read of that byte returns it. A read does not lose an event that arrives in the same cycle. Wider quantities are kept as a pair of adjacent bytes, with the high byte at the lower address, and software reads them as two byte reads.

Read data is registered. It appears one cycle after the read strobe, together with a valid flag.

Top module: `hwmon_regbank`

## Requirements
- R1: After a synchronous active-low reset, the page is 0, `rd_valid` and `rd_data` are 0, all alarm bits are clear and every storage byte reads 0x00.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high. `rd_data` carries the read value in that cycle and is 0x00 whenever `rd_valid` is low.
- R3: A write to address 0xFF loads `wr_data[2:0]` as the page number and discards bits 7:3. A read of 0xFF returns the page in bits 2:0 and zero in bits 7:3. A new page applies from the next access.
- R4: In every page, including unimplemented ones, 0x7A reads 0x50, 0x7B reads 0xC5 and 0x7C reads 0x53 (upper nibble 0x5, revision nibble 0x3). Writes to these three addresses change nothing.
- R5: Pages 0 to 3 each have their own storage. A write at an address in one page leaves the same address in the other pages unchanged.
- R6: A 16-bit value written as its high byte at address A and its low byte at A+1 reads back as those two bytes, in that order, through two byte reads.
- R7: When the page number is 4 to 7, reads of any address other than 0xFF, 0x7A, 0x7B and 0x7C return 0x00, and writes to such addresses are ignored.
- R8: In page 0, addresses 0xC1 to 0xCA are read-only alarm bytes. Event input bit 8*k+j sets bit j of byte 0xC1+k. Writes to these addresses are ignored.
- R9: Reading an alarm byte clears the bits it returned. A bit whose event input is high in the cycle of the read is set in the byte afterwards.
- R10: In pages 1 to 3, addresses 0xC1 to 0xCA are ordinary storage.
- R11: When a read and a write hit the same address in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address for this cycle's read and write |
| wr_data | input | 8 | Write data |
| alarm_evt | input | 80 | One-cycle alarm events, bit 8*k+j goes to bit j of byte 0xC1+k |
| rd_data | output | 8 | Read data, valid one cycle after the read strobe |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
Two functions can fall in the same cycle: the clear that a read of an alarm byte causes, and the capture of a new alarm event into that byte. The bench first latches one bit in an alarm byte. It then reads that byte while pulsing a different bit's event in the same cycle. The read must return only the old bit, and the following read must return only the new one. A second case re-raises a bit that is already set during its own read, and that bit must survive one more read. A read-during-write to one storage address is judged the same way: old value first, new value on the next read.

// File: rtl/hwmon_regbank_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the banked monitor register front end.
// Assumes a byte-wide register interface with an 8-bit address space.
package hwmon_regbank_pkg;

    localparam int          REG_W         = 8;
    localparam logic [7:0]  PAGE_ADDR     = 8'hFF;
    localparam logic [7:0]  VENDOR_ADDR   = 8'h7A;
    localparam logic [7:0]  CHIP_ADDR     = 8'h7B;
    localparam logic [7:0]  DEVICE_ADDR   = 8'h7C;
    localparam logic [7:0]  ALARM_BASE    = 8'hC1;

    // Which resource an address reaches under the current page.
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PAGE,
        TGT_IDENT,
        TGT_ALARM,
        TGT_STORE
    } target_e;

endpackage

// File: rtl/regbank_decode.sv
`timescale 1ns/1ps
// Address decoder: maps an address plus the active page onto one target.
// Assumes the global addresses (page register, identification bytes) win
// over every page, and that alarm bytes exist only in page 0.
module regbank_decode
    import hwmon_regbank_pkg::*;
#(
    parameter int         NUM_BANKS = 4,
    parameter int         SEL_W     = 3,
    parameter int         ALARM_REGS = 10,
    parameter int         IDX_W     = 4,
    parameter logic [7:0] VENDOR_ID = 8'h50,
    parameter logic [7:0] CHIP_ID   = 8'hC5,
    parameter logic [7:0] DEVICE_ID = 8'h53
) (
    input  logic [REG_W-1:0] addr,
    input  logic [SEL_W-1:0] page,
    output target_e          target,
    output logic [REG_W-1:0] ident_val,
    output logic [IDX_W-1:0] alarm_idx
);

    localparam int ALARM_END = int'(ALARM_BASE) + ALARM_REGS;

    logic page_live;
    logic in_alarm_span;

    // Classify the page and whether the address falls in the alarm run.
    always_comb begin
        page_live     = int'(page) < NUM_BANKS;
        in_alarm_span = (int'(addr) >= int'(ALARM_BASE)) && (int'(addr) < ALARM_END);
    end

    // Pick the target, in priority order: page register, identity, page contents.
    always_comb begin
        target    = TGT_NONE;
        ident_val = '0;
        alarm_idx = IDX_W'(addr - ALARM_BASE);
        if (addr == PAGE_ADDR) begin
            target = TGT_PAGE;
        end else if (addr == VENDOR_ADDR) begin
            target    = TGT_IDENT;
            ident_val = VENDOR_ID;
        end else if (addr == CHIP_ADDR) begin
            target    = TGT_IDENT;
            ident_val = CHIP_ID;
        end else if (addr == DEVICE_ADDR) begin
            target    = TGT_IDENT;
            ident_val = DEVICE_ID;
        end else if (!page_live) begin
            target = TGT_NONE;
        end else if (page == '0 && in_alarm_span) begin
            target = TGT_ALARM;
        end else begin
            target = TGT_STORE;
        end
    end

endmodule

// File: rtl/regbank_store.sv
`timescale 1ns/1ps
// One page of byte storage with a single write port and an unregistered read.
// Assumes the caller gates the write enable with its page and target decode.
module regbank_store
    import hwmon_regbank_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata
);

    logic [REG_W-1:0] mem [DEPTH];

    // Clear all bytes on reset, otherwise take the gated write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the byte at the shared address to the read mux.
    always_comb begin
        rdata = mem[addr];
    end

endmodule

// File: rtl/regbank_alarms.sv
`timescale 1ns/1ps
// Latched alarm bytes with clear-on-read.
// Assumes rd_hit is high only for an in-range index. An event that
// arrives in the cycle of a read is kept for the next read.
module regbank_alarms
    import hwmon_regbank_pkg::*;
#(
    parameter int ALARM_REGS = 10,
    parameter int IDX_W      = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ALARM_REGS*REG_W-1:0] evt,
    input  logic                        rd_hit,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [ALARM_REGS*REG_W-1:0] flags,
    output logic [REG_W-1:0]            rd_val
);

    logic [REG_W-1:0] latch_q [ALARM_REGS];

    for (genvar k = 0; k < ALARM_REGS; k++) begin : g_byte
        logic [REG_W-1:0] evt_k;
        logic             clr_k;

        // Slice this byte's events and detect a read of this byte.
        always_comb begin
            evt_k = evt[k*REG_W +: REG_W];
            clr_k = rd_hit && (rd_idx == IDX_W'(k));
        end

        // Set on event; on a read keep only the events arriving now.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latch_q[k] <= '0;
            end else if (clr_k) begin
                latch_q[k] <= evt_k;
            end else begin
                latch_q[k] <= latch_q[k] | evt_k;
            end
        end

        assign flags[k*REG_W +: REG_W] = latch_q[k];
    end

    // Select the byte addressed by the current read.
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < ALARM_REGS; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_val = latch_q[k];
            end
        end
    end

endmodule

// File: rtl/hwmon_regbank.sv
`timescale 1ns/1ps
// Banked register front end: page register, global identification bytes,
// per-page storage and page-0 alarm bytes behind one byte interface.
// Assumes the bus protocol layer has already decoded each access. Read data
// is registered, so it returns one cycle after the strobe.
module hwmon_regbank
    import hwmon_regbank_pkg::*;
#(
    parameter int         NUM_BANKS  = 4,
    parameter int         SEL_W      = 3,
    parameter int         BANK_DEPTH = 256,
    parameter int         ALARM_REGS = 10,
    parameter logic [7:0] VENDOR_ID  = 8'h50,
    parameter logic [7:0] CHIP_ID    = 8'hC5,
    parameter logic [3:0] DEV_REV    = 4'h3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [REG_W-1:0]            reg_addr,
    input  logic [REG_W-1:0]            wr_data,
    input  logic [ALARM_REGS*REG_W-1:0] alarm_evt,
    output logic [REG_W-1:0]            rd_data,
    output logic                        rd_valid
);

    localparam int         ADDR_W    = $clog2(BANK_DEPTH);
    localparam int         IDX_W     = $clog2(ALARM_REGS);
    localparam logic [7:0] DEVICE_ID = {4'h5, DEV_REV};

    logic [SEL_W-1:0]            page_q;
    target_e                     target;
    logic [REG_W-1:0]            ident_val;
    logic [IDX_W-1:0]            alarm_idx;
    logic [ALARM_REGS*REG_W-1:0] alarm_flags;
    logic [REG_W-1:0]            alarm_val;
    logic [REG_W-1:0]            store_rd [NUM_BANKS];
    logic [REG_W-1:0]            store_sel;
    logic [REG_W-1:0]            rd_mux;
    logic                        alarm_rd_hit;
    logic [REG_W-1:0]            rd_data_q;
    logic                        rd_valid_q;

    regbank_decode #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .ALARM_REGS(ALARM_REGS),
        .IDX_W     (IDX_W),
        .VENDOR_ID (VENDOR_ID),
        .CHIP_ID   (CHIP_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_decode (
        .addr     (reg_addr),
        .page     (page_q),
        .target   (target),
        .ident_val(ident_val),
        .alarm_idx(alarm_idx)
    );

    // Load a new page number on a write to the page register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_en && target == TGT_PAGE) begin
            page_q <= wr_data[SEL_W-1:0];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;

        // Gate the write to this page only.
        always_comb begin
            bank_we = wr_en && (target == TGT_STORE) && (page_q == SEL_W'(b));
        end

        regbank_store #(
            .DEPTH (BANK_DEPTH),
            .ADDR_W(ADDR_W)
        ) u_store (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (bank_we),
            .addr (reg_addr[ADDR_W-1:0]),
            .wdata(wr_data),
            .rdata(store_rd[b])
        );
    end

    // A read of an alarm byte triggers its clear.
    always_comb begin
        alarm_rd_hit = rd_en && (target == TGT_ALARM);
    end

    regbank_alarms #(
        .ALARM_REGS(ALARM_REGS),
        .IDX_W     (IDX_W)
    ) u_alarms (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (alarm_evt),
        .rd_hit(alarm_rd_hit),
        .rd_idx(alarm_idx),
        .flags (alarm_flags),
        .rd_val(alarm_val)
    );

    // Pick the storage byte of the active page.
    always_comb begin
        store_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (page_q == SEL_W'(b)) begin
                store_sel = store_rd[b];
            end
        end
    end

    // Steer the addressed source onto the read path.
    always_comb begin
        unique case (target)
            TGT_PAGE:  rd_mux = REG_W'(page_q);
            TGT_IDENT: rd_mux = ident_val;
            TGT_ALARM: rd_mux = alarm_val;
            TGT_STORE: rd_mux = store_sel;
            default:   rd_mux = '0;
        endcase
    end

    // Register the read result and its valid flag; idle data is zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_data_q  <= rd_en ? rd_mux : '0;
            rd_valid_q <= rd_en;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/regbank_checker.sv
`timescale 1ns/1ps
// Property checker for the banked register front end, bound to the top.
// Observes the ports, the page register and the latched alarm flags.
module regbank_checker
    import hwmon_regbank_pkg::*;
#(
    parameter int         NUM_BANKS  = 4,
    parameter int         SEL_W      = 3,
    parameter int         ALARM_REGS = 10,
    parameter logic [7:0] VENDOR_ID  = 8'h50
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic                        rd_en,
    input logic [REG_W-1:0]            reg_addr,
    input logic [REG_W-1:0]            wr_data,
    input logic [ALARM_REGS*REG_W-1:0] alarm_evt,
    input logic [REG_W-1:0]            rd_data,
    input logic                        rd_valid,
    input logic [SEL_W-1:0]            page_q,
    input logic [ALARM_REGS*REG_W-1:0] alarm_flags
);

    logic global_addr;
    assign global_addr = (reg_addr == PAGE_ADDR) || (reg_addr == VENDOR_ADDR)
                      || (reg_addr == CHIP_ADDR) || (reg_addr == DEVICE_ADDR);

    p_valid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_quiet_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    p_page_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == PAGE_ADDR) |=> page_q == $past(wr_data[SEL_W-1:0]));

    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == PAGE_ADDR) |=> $stable(page_q));

    p_page_read_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == PAGE_ADDR) |=> rd_data[REG_W-1:SEL_W] == '0);

    p_vendor_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == VENDOR_ADDR) |=> rd_data == VENDOR_ID);

    p_dead_page_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(page_q) >= NUM_BANKS && !global_addr) |=> rd_data == '0);

    p_event_captured_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (alarm_flags & $past(alarm_evt)) == $past(alarm_evt));

    p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && page_q == '0 && reg_addr == ALARM_BASE && alarm_evt[REG_W-1:0] == '0)
        |=> alarm_flags[REG_W-1:0] == '0);

endmodule

bind hwmon_regbank regbank_checker #(
    .NUM_BANKS (NUM_BANKS),
    .SEL_W     (SEL_W),
    .ALARM_REGS(ALARM_REGS),
    .VENDOR_ID (VENDOR_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .reg_addr   (reg_addr),
    .wr_data    (wr_data),
    .alarm_evt  (alarm_evt),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .page_q     (page_q),
    .alarm_flags(alarm_flags)
);

// File: tb/hwmon_regbank_test.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked in one loop, then directed
// tests for reset, alarm clear/set collisions and read-during-write.
module hwmon_regbank_test;

    localparam int ALARM_REGS = 10;
    localparam int EVT_W      = ALARM_REGS * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [7:0]       reg_addr = '0;
    logic [7:0]       wr_data = '0;
    logic [EVT_W-1:0] alarm_evt = '0;
    logic [7:0]       rd_data;
    logic             rd_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hwmon_regbank uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .alarm_evt(alarm_evt),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Vector: {is_read, req number, address, data (write value or expected)}.
    localparam int NV = 34;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'd3,  8'hFF, 8'h00},  // R3 page reads 0
        {1'b1, 4'd4,  8'h7A, 8'h50},  // R4 vendor
        {1'b0, 4'd4,  8'h7A, 8'hAA},  // R4 write to identity
        {1'b1, 4'd4,  8'h7A, 8'h50},  // R4 unchanged
        {1'b0, 4'd6,  8'h40, 8'h12},  // R6 high byte
        {1'b0, 4'd6,  8'h41, 8'h34},  // R6 low byte
        {1'b1, 4'd6,  8'h40, 8'h12},  // R6
        {1'b1, 4'd6,  8'h41, 8'h34},  // R6
        {1'b0, 4'd3,  8'hFF, 8'h01},  // R3 select page 1
        {1'b1, 4'd3,  8'hFF, 8'h01},  // R3
        {1'b1, 4'd5,  8'h40, 8'h00},  // R5 page 1 untouched
        {1'b0, 4'd5,  8'h40, 8'h9A},  // R5
        {1'b1, 4'd5,  8'h40, 8'h9A},  // R5
        {1'b0, 4'd3,  8'hFF, 8'h00},  // R3 back to page 0
        {1'b1, 4'd5,  8'h40, 8'h12},  // R5 page 0 kept
        {1'b0, 4'd3,  8'hFF, 8'h03},  // R3 page 3
        {1'b1, 4'd4,  8'h7B, 8'hC5},  // R4 chip
        {1'b1, 4'd4,  8'h7C, 8'h53},  // R4 device
        {1'b0, 4'd5,  8'h10, 8'h77},  // R5
        {1'b1, 4'd5,  8'h10, 8'h77},  // R5
        {1'b0, 4'd3,  8'hFF, 8'h06},  // R3 page 6 (unimplemented)
        {1'b1, 4'd3,  8'hFF, 8'h06},  // R3
        {1'b0, 4'd7,  8'h10, 8'h55},  // R7 write ignored
        {1'b1, 4'd7,  8'h10, 8'h00},  // R7 reads zero
        {1'b1, 4'd4,  8'h7A, 8'h50},  // R4 identity in dead page
        {1'b0, 4'd3,  8'hFF, 8'hFD},  // R3 upper bits dropped -> 5
        {1'b1, 4'd3,  8'hFF, 8'h05},  // R3
        {1'b0, 4'd3,  8'hFF, 8'h01},  // R3 page 1
        {1'b0, 4'd10, 8'hC1, 8'h3C},  // R10 ordinary storage
        {1'b1, 4'd10, 8'hC1, 8'h3C},  // R10
        {1'b0, 4'd3,  8'hFF, 8'h00},  // R3 page 0
        {1'b0, 4'd8,  8'hC1, 8'hFF},  // R8 write to alarm ignored
        {1'b1, 4'd8,  8'hC1, 8'h00},  // R8
        {1'b1, 4'd3,  8'hFF, 8'h00}   // R3
    };

    // Record one comparison; print a FAIL line on mismatch.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes, then sample after the edge that took them.
    task automatic cycle(input logic w, input logic r, input logic [7:0] a,
                         input logic [7:0] d, input logic [EVT_W-1:0] ev);
        @(negedge clk);
        wr_en = w; rd_en = r; reg_addr = a; wr_data = d; alarm_evt = ev;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; alarm_evt = '0;
    endtask

    // Read one address and compare data and valid.
    task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        cycle(1'b0, 1'b1, a, 8'h00, '0);
        check({req, " valid"}, {7'b0, rd_valid}, 8'h01);
        check(req, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [EVT_W-1:0] ev;
        do_reset();

        // R1: reset state at the ports
        @(negedge clk);
        check("R1 valid", {7'b0, rd_valid}, 8'h00);
        check("R1 data", rd_data, 8'h00);
        read_chk("R1 storage", 8'h40, 8'h00);
        // R2: valid drops when no read follows
        @(negedge clk);
        check("R2 idle valid", {7'b0, rd_valid}, 8'h00);
        check("R2 idle data", rd_data, 8'h00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][19:16], i);
            if (VEC[i][20]) read_chk(tag, VEC[i][15:8], VEC[i][7:0]);
            else            cycle(1'b1, 1'b0, VEC[i][15:8], VEC[i][7:0], '0);
        end

        // R8: events latch into the right byte and bit (page is 0 here)
        ev = '0; ev[7] = 1'b1; ev[72] = 1'b1;
        cycle(1'b0, 1'b0, 8'h00, 8'h00, ev);
        read_chk("R8 byte C1", 8'hC1, 8'h80);
        read_chk("R9 cleared C1", 8'hC1, 8'h00);
        read_chk("R8 byte CA", 8'hCA, 8'h01);

        // R9: new event in the read cycle survives the clear
        ev = '0; ev[16+5] = 1'b1;
        cycle(1'b0, 1'b0, 8'h00, 8'h00, ev);
        ev = '0; ev[16+2] = 1'b1;
        cycle(1'b0, 1'b1, 8'hC3, 8'h00, ev);
        check("R9 collide old", rd_data, 8'h20);
        read_chk("R9 collide new", 8'hC3, 8'h04);
        // R9: re-raised bit during its own read stays set
        ev = '0; ev[16+2] = 1'b1;
        cycle(1'b0, 1'b0, 8'h00, 8'h00, ev);
        cycle(1'b0, 1'b1, 8'hC3, 8'h00, ev);
        check("R9 reraise read", rd_data, 8'h04);
        read_chk("R9 reraise kept", 8'hC3, 8'h04);
        read_chk("R9 finally clear", 8'hC3, 8'h00);

        // R11: read and write same address in one cycle
        cycle(1'b1, 1'b1, 8'h40, 8'h99, '0);
        check("R11 old value", rd_data, 8'h12);
        read_chk("R11 new value", 8'h40, 8'h99);

        // R1: a second reset restores page and storage
        cycle(1'b1, 1'b0, 8'hFF, 8'h02, '0);
        do_reset();
        read_chk("R1 page after reset", 8'hFF, 8'h00);
        read_chk("R1 storage after reset", 8'h40, 8'h00);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule